// File: doc/BRIEF.md
# Stereo/Mono Channel Converter

This block carries two independent audio sample streams: a capture lane and a playback lane. It sits between an audio FIFO and a serial audio port. Each lane takes a valid/ready stream of signed samples and re-emits it on a valid/ready output. A per-lane route code chooses what happens to the stream. It can pass beats through unchanged. It can fold a two-channel frame into one sample, keeping channel 0, keeping channel 1, or averaging the two. It can also expand each mono sample into a two-channel frame whose second channel is either a copy of the sample or zero. Every input beat carries a frame-start flag, and every output beat carries one too.

Samples are right-justified in a `DATA_W`-bit word. A width code tells the averager how many low bits form the sample. Each lane runs a small state machine with three states:
- `ST_FIRST` waits for a channel-0 beat, or for the only beat of a frame.
- `ST_PAIR` holds channel 0 of a frame that is being folded.
- `ST_DUP` holds the second beat of a frame that is being expanded.

The transitions are:
- `FIRST->PAIR`: a channel 0 is accepted while folding.
- `PAIR->PAIR`: a beat with the frame-start flag replaces the held channel 0.
- `PAIR->FIRST`: channel 1 is accepted and the folded sample is loaded.
- `FIRST->DUP`: a mono sample is accepted and its first beat is loaded.
- `DUP->FIRST`: the second beat is loaded.
- `FIRST->FIRST`: a pass-through beat.

A one-entry output register drives each lane's output port.

Top module: `chanconv_top`

## Requirements
- R1: After reset both lanes have `out_valid` low. With route 0 selected, `in_ready` is high.
- R2: Route code 0 or 3 (pass) forwards every accepted beat unchanged, including its frame-start flag, in order.
- R3: Route code 1 (fold) with pick code 0 emits, for each pair of accepted beats, the first beat of the pair (channel 0) and discards the second.
- R4: Route code 1 with pick code 1 emits the second beat of each pair (channel 1) and discards the first.
- R5: Route code 1 with pick code 2 or 3 emits the floor of the mean of the two samples, read as signed values. Width code 0 uses bits [7:0], code 1 uses bits [15:0], and codes 2 or 3 use the whole word. The result is sign-extended to the full word.
- R6: In fold mode, exactly one output beat is produced for every two channel beats, and every output beat has its frame-start flag set.
- R7: In fold mode, a beat carrying the frame-start flag that arrives while channel 0 is held replaces the held sample and starts a new pair.
- R8: Route code 2 (expand) with fill code 0 emits, for each accepted sample, two beats. The first is the sample with the frame-start flag set. The second is an all-zero word with the flag clear.
- R9: Route code 2 with fill code 1 emits two beats per sample. Both carry the sample; only the first has the frame-start flag set.
- R10: While `out_valid` is high and `out_ready` is low, the output beat holds steady. No beat is ever lost or duplicated under any pattern of backpressure.
- R11: In expand mode, the input frame-start flag has no effect. Each accepted sample yields one two-beat frame.
- R12: The capture and playback lanes use separate configuration inputs and operate without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_route | input | 2 | Capture route: 0/3 pass, 1 fold, 2 expand |
| cap_pick | input | 2 | Capture fold pick: 0 ch0, 1 ch1, 2/3 average |
| cap_fill | input | 1 | Capture expand fill: 0 zero, 1 copy |
| cap_wid | input | 2 | Capture sample width: 0 8-bit, 1 16-bit, 2/3 full word |
| cap_in_valid | input | 1 | Capture input beat valid |
| cap_in_ready | output | 1 | Capture input beat accepted |
| cap_in_data | input | DATA_W | Capture input sample |
| cap_in_first | input | 1 | Capture input frame-start flag |
| cap_out_valid | output | 1 | Capture output beat valid |
| cap_out_ready | input | 1 | Capture downstream ready |
| cap_out_data | output | DATA_W | Capture output sample |
| cap_out_first | output | 1 | Capture output frame-start flag |
| ply_route | input | 2 | Playback route, same coding as capture |
| ply_pick | input | 2 | Playback fold pick |
| ply_fill | input | 1 | Playback expand fill |
| ply_wid | input | 2 | Playback sample width |
| ply_in_valid | input | 1 | Playback input beat valid |
| ply_in_ready | output | 1 | Playback input beat accepted |
| ply_in_data | input | DATA_W | Playback input sample |
| ply_in_first | input | 1 | Playback input frame-start flag |
| ply_out_valid | output | 1 | Playback output beat valid |
| ply_out_ready | input | 1 | Playback downstream ready |
| ply_out_data | output | DATA_W | Playback output sample |
| ply_out_first | output | 1 | Playback output frame-start flag |

## Verification
Pass-through traffic with random frame flags shows that the flag and data reach the output untouched. Folding with each pick code on paired random words separates channel 0 from channel 1 from the mean. Hand-picked averaging pairs (both extremes, minus one with zero, and odd sums of negative values) at each width show floor rounding and whether the width code really masks the upper bits. A stream with extra frame-start beats shows realignment. Expand traffic with random input flags, under both fill codes and heavy random backpressure, shows zero versus copy fill, that the input flag is ignored, and that no beat is lost or doubled when the output stalls in the middle of a frame.

// File: rtl/chanconv_pkg.sv
package chanconv_pkg;

    typedef enum logic [1:0] {
        ROUTE_PASS     = 2'd0,
        ROUTE_FOLD     = 2'd1,
        ROUTE_EXPAND   = 2'd2,
        ROUTE_PASS_ALT = 2'd3
    } route_e;

    typedef enum logic [1:0] {
        PICK_CH0     = 2'd0,
        PICK_CH1     = 2'd1,
        PICK_MEAN    = 2'd2,
        PICK_MEAN_AL = 2'd3
    } pick_e;

    typedef enum logic {
        FILL_ZERO = 1'b0,
        FILL_COPY = 1'b1
    } fill_e;

    typedef enum logic [1:0] {
        ST_FIRST = 2'd0,
        ST_PAIR  = 2'd1,
        ST_DUP   = 2'd2
    } lane_st_e;

endpackage

// File: rtl/chanconv_mean.sv
module chanconv_mean #(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        wid,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] mean
);
    localparam int SUM_W = DATA_W + 1;
    localparam int NARROW_CNT = 2;

    logic [SUM_W-1:0] ext_a [NARROW_CNT+1];
    logic [SUM_W-1:0] ext_b [NARROW_CNT+1];
    logic [SUM_W-1:0] sel_a;
    logic [SUM_W-1:0] sel_b;
    logic [SUM_W-1:0] sum;

    // One sign-extended candidate per supported narrow width (8 << k).
    for (genvar k = 0; k < NARROW_CNT; k++) begin : g_narrow
        localparam int W = 8 << k;
        assign ext_a[k] = {{(SUM_W-W){a[W-1]}}, a[W-1:0]};
        assign ext_b[k] = {{(SUM_W-W){b[W-1]}}, b[W-1:0]};
    end
    assign ext_a[NARROW_CNT] = {a[DATA_W-1], a};
    assign ext_b[NARROW_CNT] = {b[DATA_W-1], b};

    always_comb begin
        unique case (wid)
            2'd0:    begin sel_a = ext_a[0];          sel_b = ext_b[0];          end
            2'd1:    begin sel_a = ext_a[1];          sel_b = ext_b[1];          end
            default: begin sel_a = ext_a[NARROW_CNT]; sel_b = ext_b[NARROW_CNT]; end
        endcase
    end

    // Sum with one guard bit, then drop the LSB: arithmetic shift, floor rounding.
    assign sum  = sel_a + sel_b;
    assign mean = sum[SUM_W-1:1];

endmodule

// File: rtl/chanconv_obuf.sv
module chanconv_obuf #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              ld_first,
    output logic              free,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_first
);
    assign free = !out_valid || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_first <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= ld_data;
            out_first <= ld_first;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R10
    hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_first)));

    // R10
    load_only_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!out_valid || out_ready));

endmodule

// File: rtl/chanconv_lane.sv
module chanconv_lane
    import chanconv_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        route,
    input  logic [1:0]        pick,
    input  logic              fill,
    input  logic [1:0]        wid,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_first,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_first
);
    route_e   route_s;
    pick_e    pick_s;
    fill_e    fill_s;
    lane_st_e state_q;
    lane_st_e state_d;

    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] hold_d;
    logic              hold_en;
    logic [DATA_W-1:0] mean_w;
    logic [DATA_W-1:0] folded;
    logic              load;
    logic [DATA_W-1:0] ld_data;
    logic              ld_first;
    logic              free;

    assign route_s = route_e'(route);
    assign pick_s  = pick_e'(pick);
    assign fill_s  = fill_e'(fill);

    chanconv_mean #(.DATA_W(DATA_W)) u_mean (
        .wid  (wid),
        .a    (hold_q),
        .b    (in_data),
        .mean (mean_w)
    );

    chanconv_obuf #(.DATA_W(DATA_W)) u_obuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .ld_data   (ld_data),
        .ld_first  (ld_first),
        .free      (free),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_first (out_first)
    );

    always_comb begin
        unique case (pick_s)
            PICK_CH0:     folded = hold_q;
            PICK_CH1:     folded = in_data;
            PICK_MEAN,
            PICK_MEAN_AL: folded = mean_w;
        endcase
    end

    // State register and held sample.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FIRST;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (hold_en) begin
                hold_q <= hold_d;
            end
        end
    end

    // Next state and output-side controls.
    always_comb begin
        state_d  = state_q;
        in_ready = 1'b0;
        load     = 1'b0;
        ld_data  = '0;
        ld_first = 1'b0;
        hold_en  = 1'b0;
        hold_d   = in_data;
        unique case (state_q)
            ST_FIRST: begin
                unique case (route_s)
                    ROUTE_FOLD: begin
                        in_ready = 1'b1;
                        if (in_valid) begin
                            hold_en = 1'b1;
                            state_d = ST_PAIR;
                        end
                    end
                    ROUTE_EXPAND: begin
                        in_ready = free;
                        if (in_valid && free) begin
                            load     = 1'b1;
                            ld_data  = in_data;
                            ld_first = 1'b1;
                            hold_en  = 1'b1;
                            hold_d   = (fill_s == FILL_COPY) ? in_data : '0;
                            state_d  = ST_DUP;
                        end
                    end
                    ROUTE_PASS,
                    ROUTE_PASS_ALT: begin
                        in_ready = free;
                        if (in_valid && free) begin
                            load     = 1'b1;
                            ld_data  = in_data;
                            ld_first = in_first;
                        end
                    end
                endcase
            end
            ST_PAIR: begin
                in_ready = free;
                if (in_valid && free) begin
                    if (in_first) begin
                        hold_en = 1'b1;
                    end else begin
                        load     = 1'b1;
                        ld_data  = folded;
                        ld_first = 1'b1;
                        state_d  = ST_FIRST;
                    end
                end
            end
            ST_DUP: begin
                if (free) begin
                    load     = 1'b1;
                    ld_data  = hold_q;
                    ld_first = 1'b0;
                    state_d  = ST_FIRST;
                end
            end
            default: state_d = ST_FIRST;
        endcase
    end

    // R6
    fold_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route_s == ROUTE_FOLD && out_valid) |-> out_first);

    // R8
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_first && route_s == ROUTE_EXPAND && fill_s == FILL_ZERO)
        |=> (out_valid && !out_first && out_data == '0));

    // R9
    copy_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_first && route_s == ROUTE_EXPAND && fill_s == FILL_COPY)
        |=> (out_valid && !out_first && out_data == $past(out_data)));

    // R11
    expand_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route_s == ROUTE_EXPAND && in_valid && in_ready) |=> !in_ready);

    // R10
    stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route_s != ROUTE_FOLD && out_valid && !out_ready) |-> !in_ready);

endmodule

// File: rtl/chanconv_top.sv
module chanconv_top #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cap_route,
    input  logic [1:0]        cap_pick,
    input  logic              cap_fill,
    input  logic [1:0]        cap_wid,
    input  logic              cap_in_valid,
    output logic              cap_in_ready,
    input  logic [DATA_W-1:0] cap_in_data,
    input  logic              cap_in_first,
    output logic              cap_out_valid,
    input  logic              cap_out_ready,
    output logic [DATA_W-1:0] cap_out_data,
    output logic              cap_out_first,
    input  logic [1:0]        ply_route,
    input  logic [1:0]        ply_pick,
    input  logic              ply_fill,
    input  logic [1:0]        ply_wid,
    input  logic              ply_in_valid,
    output logic              ply_in_ready,
    input  logic [DATA_W-1:0] ply_in_data,
    input  logic              ply_in_first,
    output logic              ply_out_valid,
    input  logic              ply_out_ready,
    output logic [DATA_W-1:0] ply_out_data,
    output logic              ply_out_first
);
    chanconv_lane #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .route     (cap_route),
        .pick      (cap_pick),
        .fill      (cap_fill),
        .wid       (cap_wid),
        .in_valid  (cap_in_valid),
        .in_ready  (cap_in_ready),
        .in_data   (cap_in_data),
        .in_first  (cap_in_first),
        .out_valid (cap_out_valid),
        .out_ready (cap_out_ready),
        .out_data  (cap_out_data),
        .out_first (cap_out_first)
    );

    chanconv_lane #(.DATA_W(DATA_W)) u_ply (
        .clk       (clk),
        .rst_n     (rst_n),
        .route     (ply_route),
        .pick      (ply_pick),
        .fill      (ply_fill),
        .wid       (ply_wid),
        .in_valid  (ply_in_valid),
        .in_ready  (ply_in_ready),
        .in_data   (ply_in_data),
        .in_first  (ply_in_first),
        .out_valid (ply_out_valid),
        .out_ready (ply_out_ready),
        .out_data  (ply_out_data),
        .out_first (ply_out_first)
    );

endmodule

// File: tb/chanconv_top_tb_top.sv
module chanconv_top_tb_top;

    typedef struct packed {
        logic [31:0] d;
        logic        f;
        logic [7:0]  rq;
    } exp_t;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic [1:0]  route [2];
    logic [1:0]  pick  [2];
    logic        fill  [2];
    logic [1:0]  wid   [2];
    logic        iv    [2];
    logic [31:0] idat  [2];
    logic        ifst  [2];
    logic        ordy  [2];

    logic        irdy  [2];
    logic        ov    [2];
    logic [31:0] od    [2];
    logic        of    [2];

    logic        c_irdy, c_ov, c_of, p_irdy, p_ov, p_of;
    logic [31:0] c_od, p_od;

    int checks = 0;
    int fails  = 0;
    int stall_lvl = 0;

    exp_t q0[$];
    exp_t q1[$];
    logic [31:0] held [2];
    bit          have [2];
    bit          realn[2];
    bit          was_stall [2];
    logic [31:0] pd [2];
    logic        pf [2];

    chanconv_top #(.DATA_W(32)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cap_route     (route[0]),
        .cap_pick      (pick[0]),
        .cap_fill      (fill[0]),
        .cap_wid       (wid[0]),
        .cap_in_valid  (iv[0]),
        .cap_in_ready  (c_irdy),
        .cap_in_data   (idat[0]),
        .cap_in_first  (ifst[0]),
        .cap_out_valid (c_ov),
        .cap_out_ready (ordy[0]),
        .cap_out_data  (c_od),
        .cap_out_first (c_of),
        .ply_route     (route[1]),
        .ply_pick      (pick[1]),
        .ply_fill      (fill[1]),
        .ply_wid       (wid[1]),
        .ply_in_valid  (iv[1]),
        .ply_in_ready  (p_irdy),
        .ply_in_data   (idat[1]),
        .ply_in_first  (ifst[1]),
        .ply_out_valid (p_ov),
        .ply_out_ready (ordy[1]),
        .ply_out_data  (p_od),
        .ply_out_first (p_of)
    );

    always_comb begin
        irdy[0] = c_irdy; ov[0] = c_ov; od[0] = c_od; of[0] = c_of;
        irdy[1] = p_irdy; ov[1] = p_ov; od[1] = p_od; of[1] = p_of;
    end

    function automatic logic [31:0] mean_ref(logic [31:0] a, logic [31:0] b, logic [1:0] w);
        longint sa, sb, s;
        case (w)
            2'd0:    begin sa = longint'($signed(a[7:0]));  sb = longint'($signed(b[7:0]));  end
            2'd1:    begin sa = longint'($signed(a[15:0])); sb = longint'($signed(b[15:0])); end
            default: begin sa = longint'($signed(a));       sb = longint'($signed(b));       end
        endcase
        s = (sa + sb) >>> 1;
        return s[31:0];
    endfunction

    function automatic void push(int ln, logic [31:0] d, logic f, int rq);
        exp_t e;
        e.d = d; e.f = f; e.rq = 8'(rq);
        if (ln == 0) q0.push_back(e); else q1.push_back(e);
    endfunction

    function automatic void model_in(int ln, logic [31:0] d, logic f);
        logic [31:0] r;
        int rq;
        case (route[ln])
            2'd1: begin
                if (!have[ln]) begin
                    held[ln] = d; have[ln] = 1'b1; realn[ln] = 1'b0;
                end else if (f) begin
                    // R7: frame start replaces held channel 0
                    held[ln] = d; realn[ln] = 1'b1;
                end else begin
                    // R3 ch0, R4 ch1, R5 mean; R6 every folded beat flagged
                    if (pick[ln] == 2'd0)      begin r = held[ln]; rq = 3; end
                    else if (pick[ln] == 2'd1) begin r = d;        rq = 4; end
                    else begin r = mean_ref(held[ln], d, wid[ln]); rq = 5; end
                    if (realn[ln]) rq = 7;
                    push(ln, r, 1'b1, rq);
                    have[ln] = 1'b0;
                end
            end
            2'd2: begin
                // R8 zero fill, R9 copy fill, R11 input flag ignored
                push(ln, d, 1'b1, fill[ln] ? 9 : 8);
                push(ln, fill[ln] ? d : 32'h0, 1'b0, fill[ln] ? 9 : 8);
            end
            default: push(ln, d, f, 2); // R2 pass
        endcase
    endfunction

    // Cycle-by-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        for (int ln = 0; ln < 2; ln++) begin
            if (!rst_n) begin
                was_stall[ln] = 1'b0;
            end else begin
                if (was_stall[ln]) begin
                    checks++; // R10 stalled beat must hold
                    if (!ov[ln] || od[ln] !== pd[ln] || of[ln] !== pf[ln]) begin
                        fails++;
                        $display("FAIL R10 lane %0d stall: got v%0b %h f%0b, expected v1 %h f%0b",
                                 ln, ov[ln], od[ln], of[ln], pd[ln], pf[ln]);
                    end
                end
                was_stall[ln] = ov[ln] && !ordy[ln];
                pd[ln] = od[ln];
                pf[ln] = of[ln];
                if (iv[ln] && irdy[ln]) model_in(ln, idat[ln], ifst[ln]);
                if (ov[ln] && ordy[ln]) begin
                    exp_t e;
                    int sz;
                    sz = (ln == 0) ? q0.size() : q1.size();
                    checks++;
                    if (sz == 0) begin
                        fails++;
                        $display("FAIL R10 lane %0d extra beat: got %h f%0b, expected none",
                                 ln, od[ln], of[ln]);
                    end else begin
                        e = (ln == 0) ? q0.pop_front() : q1.pop_front();
                        if (od[ln] !== e.d || of[ln] !== e.f) begin
                            fails++;
                            $display("FAIL R%0d lane %0d: got %h f%0b, expected %h f%0b",
                                     e.rq, ln, od[ln], of[ln], e.d, e.f);
                        end
                    end
                end
            end
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_ready
        initial begin
            ordy[g] = 1'b1;
            forever begin
                @(posedge clk);
                #1;
                case (stall_lvl)
                    0:       ordy[g] = 1'b1;
                    1:       ordy[g] = ($urandom_range(0, 3) != 0);
                    default: ordy[g] = ($urandom_range(0, 1) != 0);
                endcase
            end
        end
    end

    task automatic send(int ln, logic [31:0] d, logic f);
        iv[ln] = 1'b1; idat[ln] = d; ifst[ln] = f;
        @(negedge clk);
        while (!irdy[ln]) @(negedge clk);
        @(posedge clk);
        #1;
        iv[ln] = 1'b0;
    endtask

    task automatic run_lane(int ln, int n);
        for (int i = 0; i < n; i++) begin
            logic f;
            f = (route[ln] == 2'd1) ? (i % 2 == 0) : 1'($urandom_range(0, 1));
            send(ln, $urandom, f);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        iv[0] = 1'b0; iv[1] = 1'b0;
        q0.delete(); q1.delete();
        have[0] = 1'b0; have[1] = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic drain();
        int n = 0;
        while ((q0.size() + q1.size()) != 0 && n < 500) begin
            @(negedge clk);
            n++;
        end
        checks++;
        if ((q0.size() + q1.size()) != 0) begin
            fails++;
            $display("FAIL R10 lost beats: got %0d pending, expected 0", q0.size() + q1.size());
        end
    endtask

    task automatic cfg(int ln, logic [1:0] r, logic [1:0] p, logic fl, logic [1:0] w);
        route[ln] = r; pick[ln] = p; fill[ln] = fl; wid[ln] = w;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog: got hung run, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            iv[i] = 1'b0; idat[i] = '0; ifst[i] = 1'b0; cfg(i, 2'd0, 2'd0, 1'b0, 2'd2);
        end
        rst_n = 1'b0;
        do_reset();

        // R1 reset state
        @(negedge clk);
        for (int ln = 0; ln < 2; ln++) begin
            checks++;
            if (ov[ln] !== 1'b0 || irdy[ln] !== 1'b1) begin
                fails++;
                $display("FAIL R1 lane %0d: got valid %0b ready %0b, expected valid 0 ready 1",
                         ln, ov[ln], irdy[ln]);
            end
        end

        // R2 pass, both codes, with backpressure
        stall_lvl = 1;
        cfg(0, 2'd0, 2'd0, 1'b0, 2'd2); cfg(1, 2'd3, 2'd0, 1'b0, 2'd2);
        fork run_lane(0, 20); run_lane(1, 20); join
        drain();

        // R3 / R4 / R12 lanes folding concurrently with different picks
        do_reset();
        cfg(0, 2'd1, 2'd0, 1'b0, 2'd2); cfg(1, 2'd1, 2'd1, 1'b0, 2'd2);
        fork run_lane(0, 24); run_lane(1, 24); join
        drain();

        // R5 mean corners: full word on capture, 8-bit on playback
        do_reset();
        stall_lvl = 0;
        cfg(0, 2'd1, 2'd2, 1'b0, 2'd2); cfg(1, 2'd1, 2'd2, 1'b0, 2'd0);
        fork
            begin
                send(0, 32'hFFFFFFFF, 1); send(0, 32'h00000000, 0);
                send(0, 32'h7FFFFFFF, 1); send(0, 32'h7FFFFFFF, 0);
                send(0, 32'h80000000, 1); send(0, 32'h80000000, 0);
                send(0, 32'h80000000, 1); send(0, 32'h7FFFFFFF, 0);
                send(0, 32'hFFFFFFFD, 1); send(0, 32'h00000000, 0);
            end
            begin
                send(1, 32'hABCDEF7F, 1); send(1, 32'h12345601, 0);
                send(1, 32'h55555580, 1); send(1, 32'h000000FF, 0);
                send(1, 32'h00000080, 1); send(1, 32'hFFFFFF80, 0);
                send(1, 32'h0000007F, 1); send(1, 32'h0000007F, 0);
            end
        join
        drain();

        // R5 16-bit and alternate mean/width codes under backpressure
        do_reset();
        stall_lvl = 2;
        cfg(0, 2'd1, 2'd3, 1'b0, 2'd1); cfg(1, 2'd1, 2'd2, 1'b0, 2'd3);
        fork
            begin
                send(0, 32'hDEAD8000, 1); send(0, 32'hBEEF7FFF, 0);
                send(0, 32'h0000FFFF, 1); send(0, 32'h0000FFFE, 0);
                run_lane(0, 16);
            end
            run_lane(1, 16);
        join
        drain();

        // R7 realignment on extra frame-start beats
        do_reset();
        stall_lvl = 1;
        cfg(0, 2'd1, 2'd0, 1'b0, 2'd2); cfg(1, 2'd1, 2'd1, 1'b0, 2'd2);
        fork
            begin
                send(0, 32'hA0, 1); send(0, 32'hB0, 1); send(0, 32'hC0, 0);
                send(0, 32'hD0, 1); send(0, 32'hE0, 0);
            end
            begin
                send(1, 32'hA1, 1); send(1, 32'hB1, 1); send(1, 32'hC1, 0);
                send(1, 32'hD1, 1); send(1, 32'hE1, 0);
            end
        join
        drain();

        // R8 / R9 / R11 expand with random input flags, heavy stalls
        do_reset();
        stall_lvl = 2;
        cfg(0, 2'd2, 2'd0, 1'b0, 2'd2); cfg(1, 2'd2, 2'd0, 1'b1, 2'd2);
        fork run_lane(0, 20); run_lane(1, 20); join
        drain();

        // R10 / R12 mixed random configurations
        for (int rep = 0; rep < 6; rep++) begin
            do_reset();
            stall_lvl = rep % 3;
            for (int ln = 0; ln < 2; ln++)
                cfg(ln, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                    1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));
            fork run_lane(0, 30); run_lane(1, 30); join
            drain();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule